// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block keeps a small, fully associative set of recent page translations. Each translation maps a virtual page number to a physical frame number. Every entry also records the address-space number that was current when it was installed. A requester presents a virtual page number. One clock later the block reports hit or miss and, on a hit, the frame number. It makes no memory access to do this.

On a miss, an external walker fetches the translation and hands it back through the fill port. The block tags it with the current address-space number and stores it at the next clock edge. A fill goes to one of three places, in this order of preference:
- the entry already holding the same page and space, which it overwrites;
- otherwise the lowest-numbered empty entry;
- otherwise the entry chosen by a rotating victim pointer.

Two management inputs act on the stored entries. One clears every entry at once. The other switches the current address space. With address-space tagging enabled, a switch leaves the stored entries in place and only changes which of them can match. With tagging disabled, every switch also clears all entries.

Top module: `asid_tlb`

## Requirements
- R1: After reset, every entry is empty, the current address-space number is 0, and `rsp_valid`, `rsp_hit` and `rsp_pfn` are all 0.
- R2: `rsp_valid` equals the value `lk_valid` had one clock edge earlier; the response reflects the stored entries as they were before that edge.
- R3: A lookup hits only when an entry is valid, its page number equals `lk_vpn`, and its address-space number equals the current one. On a hit, `rsp_pfn` is that entry's frame number. On a miss, `rsp_hit` is 0 and `rsp_pfn` is 0.
- R4: A fill (`fill_en`=1) is stored at the next clock edge under the current address-space number. A lookup of the same page in the same cycle as the fill misses, and a later lookup hits.
- R5: With `USE_ASID`=1, a `ctx_wr` loads `ctx_asid` as the current address-space number and keeps all entries. Entries tagged with another number do not match. After switching back to the earlier number, its entries hit again.
- R6: With `USE_ASID`=0, every `ctx_wr` empties all entries at the next clock edge.
- R7: `flush_all` empties all entries at the next clock edge. A fill presented in the same cycle is dropped.
- R8: A fill whose page number and current address-space number match a valid entry overwrites that entry's frame number. It creates no second entry, takes no empty entry and does not move the victim pointer.
- R9: A fill with no matching entry takes the lowest-numbered empty entry. If no entry is empty, it takes the entry at the victim pointer, which then steps to the next index and wraps from `ENTRIES-1` to 0. Reset and every clearing event return the pointer to 0.
- R10: At most one entry matches any lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| fill_en | input | 1 | Install a walked translation |
| fill_vpn | input | VPN_W | Page number of the fill |
| fill_pfn | input | PFN_W | Frame number of the fill |
| flush_all | input | 1 | Empty every entry |
| ctx_wr | input | 1 | Switch the current address space |
| ctx_asid | input | ASID_W | New address-space number |
| rsp_valid | output | 1 | Lookup response valid (one cycle after request) |
| rsp_hit | output | 1 | Lookup hit |
| rsp_pfn | output | PFN_W | Frame number on hit, zero on miss |

## Verification
The embedded assertions check, on every cycle:
- that at most one entry ever matches;
- that the response follows the request by exactly one edge;
- that a miss never carries a frame number;
- that a clear leaves nothing valid, and a non-clearing fill leaves its slot valid;
- that a tagged-mode switch leaves the valid set unchanged, while an untagged switch empties it;
- that a fill which does not evict leaves the victim pointer still.

Which entry is evicted, whether an overwrite really avoids a duplicate, and what a same-cycle lookup returns are visible only at the lookup port. The bench's sweeps show these by running a long fill sequence and probing every page number against the expected set of the last eight fills. It compares a tagged and an untagged instance through the same context switches.

// File: rtl/asid_tlb_pkg.sv
package asid_tlb_pkg;

  // Where a fill lands.
  typedef enum logic [1:0] {
    SLOT_REUSE = 2'd0,
    SLOT_FREE  = 2'd1,
    SLOT_EVICT = 2'd2
  } slot_src_e;

endpackage

// File: rtl/asid_tlb_store.sv
module asid_tlb_store #(
  parameter int N      = 8,
  parameter int ASID_W = 8,
  parameter int VPN_W  = 20,
  parameter int PFN_W  = 20,
  localparam int IW    = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_all,
  input  logic              wr_en,
  input  logic [IW-1:0]     wr_idx,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [PFN_W-1:0]  wr_pfn,
  input  logic [ASID_W-1:0] cur_asid,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [VPN_W-1:0]  fl_vpn,
  output logic [N-1:0]      lk_hit,
  output logic [N-1:0]      fl_hit,
  output logic [N-1:0]      vld,
  output logic [PFN_W-1:0]  lk_pfn
);

  logic [N-1:0]     vld_q;
  logic [N-1:0]     vld_d;
  logic [PFN_W-1:0] pfn_m [N];

  for (genvar i = 0; i < N; i++) begin : g_ent
    logic              sel;
    logic [ASID_W-1:0] asid_q;
    logic [VPN_W-1:0]  vpn_q;
    logic [PFN_W-1:0]  pfn_q;
    logic              asid_ok;

    assign sel      = wr_en && (wr_idx == IW'(i));
    assign vld_d[i] = clr_all ? 1'b0 : (sel ? 1'b1 : vld_q[i]);

    always_ff @(posedge clk) begin
      if (sel) begin
        asid_q <= wr_asid;
        vpn_q  <= wr_vpn;
        pfn_q  <= wr_pfn;
      end
    end

    assign asid_ok   = (asid_q == cur_asid);
    assign lk_hit[i] = vld_q[i] && asid_ok && (vpn_q == lk_vpn);
    assign fl_hit[i] = vld_q[i] && asid_ok && (vpn_q == fl_vpn);
    assign pfn_m[i]  = lk_hit[i] ? pfn_q : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  always_comb begin
    lk_pfn = '0;
    for (int i = 0; i < N; i++) lk_pfn = lk_pfn | pfn_m[i];
  end

  assign vld = vld_q;

  AST_ONE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_hit)); // R10
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> (vld_q == '0)); // R7
  AST_FILL_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr_all) |=> vld_q[$past(wr_idx)]); // R4

endmodule

// File: rtl/asid_tlb_victim.sv
module asid_tlb_victim
  import asid_tlb_pkg::*;
#(
  parameter int N   = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  vld,
  input  logic [N-1:0]  fl_hit,
  input  logic          go,
  input  logic          clr,
  output logic [IW-1:0] idx,
  output slot_src_e     src
);

  logic [IW-1:0] ptr_q;
  logic [IW-1:0] ptr_d;
  logic [IW-1:0] hit_idx;
  logic [IW-1:0] free_idx;

  always_comb begin
    hit_idx  = '0;
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (fl_hit[i]) hit_idx  = IW'(i);
      if (!vld[i])   free_idx = IW'(i);
    end
    if (|fl_hit) begin
      src = SLOT_REUSE;
      idx = hit_idx;
    end else if (!(&vld)) begin
      src = SLOT_FREE;
      idx = free_idx;
    end else begin
      src = SLOT_EVICT;
      idx = ptr_q;
    end
  end

  always_comb begin
    ptr_d = ptr_q;
    if (clr) ptr_d = '0;
    else if (go && (src == SLOT_EVICT))
      ptr_d = (ptr_q == IW'(N - 1)) ? '0 : ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  AST_PTR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !(go && (src == SLOT_EVICT))) |=> $stable(ptr_q)); // R9
  AST_EVICT_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (go && (src == SLOT_EVICT)) |-> (&vld)); // R9

endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
  import asid_tlb_pkg::*;
#(
  parameter int ENTRIES  = 8,
  parameter int ASID_W   = 8,
  parameter int VPN_W    = 20,
  parameter int PFN_W    = 20,
  parameter bit USE_ASID = 1'b1,
  localparam int IW      = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic              fill_en,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [PFN_W-1:0]  fill_pfn,
  input  logic              flush_all,
  input  logic              ctx_wr,
  input  logic [ASID_W-1:0] ctx_asid,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [PFN_W-1:0]  rsp_pfn
);

  logic [ASID_W-1:0]  cur_q, cur_d;
  logic               rv_q, rv_d;
  logic               rh_q, rh_d;
  logic [PFN_W-1:0]   rp_q, rp_d;
  logic               sw_clr;
  logic               clr_all;
  logic               fill_go;
  logic [ENTRIES-1:0] lk_hit, fl_hit, vld;
  logic [PFN_W-1:0]   lk_pfn;
  logic [IW-1:0]      wr_idx;
  slot_src_e          wr_src;

  if (USE_ASID) begin : g_tagged
    assign sw_clr = 1'b0;
    AST_SWITCH_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (ctx_wr && !flush_all && !fill_en) |=> (vld == $past(vld))); // R5
  end else begin : g_flat
    assign sw_clr = ctx_wr;
    AST_SWITCH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      ctx_wr |=> (vld == '0)); // R6
  end

  assign clr_all = flush_all | sw_clr;
  assign fill_go = fill_en & ~clr_all;

  asid_tlb_store #(
    .N(ENTRIES), .ASID_W(ASID_W), .VPN_W(VPN_W), .PFN_W(PFN_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .clr_all(clr_all),
    .wr_en(fill_go), .wr_idx(wr_idx), .wr_asid(cur_q),
    .wr_vpn(fill_vpn), .wr_pfn(fill_pfn), .cur_asid(cur_q),
    .lk_vpn(lk_vpn), .fl_vpn(fill_vpn),
    .lk_hit(lk_hit), .fl_hit(fl_hit), .vld(vld), .lk_pfn(lk_pfn)
  );

  asid_tlb_victim #(.N(ENTRIES)) u_victim (
    .clk(clk), .rst_n(rst_n), .vld(vld), .fl_hit(fl_hit),
    .go(fill_go), .clr(clr_all), .idx(wr_idx), .src(wr_src)
  );

  always_comb begin
    cur_d = ctx_wr ? ctx_asid : cur_q;
    rv_d  = lk_valid;
    rh_d  = lk_valid && (|lk_hit);
    rp_d  = rh_d ? lk_pfn : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
      rv_q  <= 1'b0;
      rh_q  <= 1'b0;
      rp_q  <= '0;
    end else begin
      cur_q <= cur_d;
      rv_q  <= rv_d;
      rh_q  <= rh_d;
      rp_q  <= rp_d;
    end
  end

  assign rsp_valid = rv_q;
  assign rsp_hit   = rh_q;
  assign rsp_pfn   = rp_q;

  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid); // R2
  AST_MISS_NO_PFN: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_hit |-> (rsp_pfn == '0)); // R3
  AST_HIT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_valid); // R2

endmodule

// File: tb/asid_tlb_tb.sv
module asid_tlb_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        lk_valid, fill_en, flush_all, ctx_wr;
  logic [19:0] lk_vpn, fill_vpn, fill_pfn;
  logic [7:0]  ctx_asid;
  logic        a_vld, a_hit, b_vld, b_hit;
  logic [19:0] a_pfn, b_pfn;
  int          vectors = 0;
  int          miscompares = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  asid_tlb #(.USE_ASID(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vpn(lk_vpn),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
    .flush_all(flush_all), .ctx_wr(ctx_wr), .ctx_asid(ctx_asid),
    .rsp_valid(a_vld), .rsp_hit(a_hit), .rsp_pfn(a_pfn)
  );

  asid_tlb #(.USE_ASID(1'b0)) u_dut_flat (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vpn(lk_vpn),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
    .flush_all(flush_all), .ctx_wr(ctx_wr), .ctx_asid(ctx_asid),
    .rsp_valid(b_vld), .rsp_hit(b_hit), .rsp_pfn(b_pfn)
  );

  function automatic logic [19:0] pfn_of(input int vpn, input int tag);
    return 20'((vpn * 7 + tag * 13 + 32'h3C1) & 32'hFFFFF);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_fill(input int vpn, input logic [19:0] pfn);
    @(negedge clk);
    fill_en = 1'b1; fill_vpn = 20'(vpn); fill_pfn = pfn;
    @(negedge clk);
    fill_en = 1'b0;
  endtask

  // Lookup; response is registered at the edge between the two negedges.
  task automatic do_look(input int vpn);
    @(negedge clk);
    lk_valid = 1'b1; lk_vpn = 20'(vpn);
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk); flush_all = 1'b1;
    @(negedge clk); flush_all = 1'b0;
  endtask

  task automatic do_switch(input int asid);
    @(negedge clk); ctx_wr = 1'b1; ctx_asid = 8'(asid);
    @(negedge clk); ctx_wr = 1'b0;
  endtask

  task automatic expect_a(input string req, input bit hit, input logic [19:0] pfn);
    check(req, {31'd0, a_vld}, 32'd1);
    check(req, {31'd0, a_hit}, {31'd0, hit});
    check(req, {12'd0, a_pfn}, hit ? {12'd0, pfn} : 32'd0);
  endtask

  task automatic expect_b(input string req, input bit hit, input logic [19:0] pfn);
    check(req, {31'd0, b_hit}, {31'd0, hit});
    check(req, {12'd0, b_pfn}, hit ? {12'd0, pfn} : 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; lk_valid = 1'b0; fill_en = 1'b0; flush_all = 1'b0; ctx_wr = 1'b0;
    lk_vpn = '0; fill_vpn = '0; fill_pfn = '0; ctx_asid = '0;
    repeat (3) @(negedge clk);
    check("R1 reset valid", {31'd0, a_vld}, 32'd0);
    check("R1 reset hit", {31'd0, a_hit}, 32'd0);
    check("R1 reset pfn", {12'd0, a_pfn}, 32'd0);
    rst_n = 1'b1;

    // R1/R2: empty after reset; response lasts one cycle only
    for (int v = 0; v < 8; v++) begin
      do_look(v);
      expect_a("R1 empty", 1'b0, '0);
    end
    @(negedge clk);
    check("R2 no request", {31'd0, a_vld}, 32'd0);

    // R9 sweep: fill 0..7 then 8..19, resident = last eight fills
    for (int v = 0; v < 8; v++) do_fill(v, pfn_of(v, 0));
    for (int k = 0; k < 12; k++) begin
      do_fill(8 + k, pfn_of(8 + k, 0));
      for (int v = 0; v < 20; v++) begin
        do_look(v);
        expect_a("R9 round robin", (v >= k + 1) && (v <= 8 + k), pfn_of(v, 0));
        expect_b("R9 round robin flat", (v >= k + 1) && (v <= 8 + k), pfn_of(v, 0));
      end
    end

    // R8: overwrite vpn 15, pointer must stay at entry 4 (holding vpn 12)
    do_fill(15, 20'h0BEEF);
    for (int v = 12; v < 20; v++) begin
      do_look(v);
      expect_a("R8 overwrite", 1'b1, (v == 15) ? 20'h0BEEF : pfn_of(v, 0));
    end
    do_fill(30, pfn_of(30, 0));
    for (int v = 12; v < 20; v++) begin
      do_look(v);
      expect_a("R8 no duplicate", v != 12, (v == 15) ? 20'h0BEEF : pfn_of(v, 0));
    end
    do_look(30);
    expect_a("R9 next victim", 1'b1, pfn_of(30, 0));

    // R4: same-cycle fill and lookup misses, later lookup hits
    do_flush();
    @(negedge clk);
    fill_en = 1'b1; fill_vpn = 20'd40; fill_pfn = 20'h12345;
    lk_valid = 1'b1; lk_vpn = 20'd40;
    @(negedge clk);
    fill_en = 1'b0; lk_valid = 1'b0;
    expect_a("R4 same cycle", 1'b0, '0);
    do_look(40);
    expect_a("R4 after fill", 1'b1, 20'h12345);

    // R7: flush beats a same-cycle fill
    @(negedge clk);
    flush_all = 1'b1; fill_en = 1'b1; fill_vpn = 20'd41; fill_pfn = 20'h00041;
    @(negedge clk);
    flush_all = 1'b0; fill_en = 1'b0;
    do_look(40);
    expect_a("R7 flushed", 1'b0, '0);
    do_look(41);
    expect_a("R7 fill dropped", 1'b0, '0);

    // R5/R6: context switches, tagged vs untagged
    do_fill(50, 20'h0AAAA);
    do_look(50);
    expect_a("R5 asid0 hit", 1'b1, 20'h0AAAA);
    expect_b("R6 before switch", 1'b1, 20'h0AAAA);
    do_switch(3);
    do_look(50);
    expect_a("R5 other asid ignored", 1'b0, '0);
    expect_b("R6 switch clears", 1'b0, '0);
    do_fill(50, 20'h0BBBB);
    do_look(50);
    expect_a("R5 asid3 hit", 1'b1, 20'h0BBBB);
    expect_b("R6 refill", 1'b1, 20'h0BBBB);
    do_switch(0);
    do_look(50);
    expect_a("R5 back to asid0", 1'b1, 20'h0AAAA);
    expect_b("R6 switch back clears", 1'b0, '0);
    do_switch(3);
    do_look(50);
    expect_a("R10 unique asid3", 1'b1, 20'h0BBBB);
    // R3: different page under same asid misses with zero frame
    do_look(51);
    expect_a("R3 vpn mismatch", 1'b0, '0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule